// File: doc/BRIEF.md
# SDRAM Mode Register Load Sequencer

This block sits on the controller side of a DDR SDRAM interface. It programs the base mode register. A requester offers a burst length code, a burst type, a CAS latency code and a DLL-reset flag, and holds `req` high. The block checks both codes against the legal encodings and stores the request. It then waits until the bank status shows every bank idle and no read or write burst running. At that point it drives exactly one load-mode-register command, with the fields packed into their address-bus bit positions and both bank-address bits low.

After the load, the block drives only NOP for a programmable number of cycles and then acknowledges. It never issues a precharge or a write, so reprogramming the mode leaves the stored data untouched. A request that carries a reserved burst-length or CAS code issues no command at all. It is acknowledged with the error flag set.

The width of the address bus is a parameter, so that the top operating-mode bit can be A11, A12 or A13. Every operating-mode bit other than the DLL-reset bit is driven to zero.

Top module: `sdram_mrs_loader`

## Requirements
- R1: While reset is asserted, and after it is released, the block drives NOP (`cmd_n` = 3'b111, meaning ras_n, cas_n and we_n all high), `ack` = 0, `err` = 0, `ba` = 0 and `addr` = 0.
- R2: The load command (`cmd_n` = 3'b000) appears only in the cycle after a clock edge at which `banks_idle` = 1 and `burst_active` = 0 were sampled. It appears at the first such edge that is the second or a later edge after the request was sampled.
- R3: During the load, `addr[2:0]` carries the burst length code. The legal codes are 3'b001 (2), 3'b010 (4) and 3'b011 (8); every other code is reserved.
- R4: During the load, `addr[3]` carries the burst type: 0 selects sequential and 1 selects interleaved.
- R5: During the load, `addr[6:4]` carries the CAS code. The legal codes are 3'b010 (latency 2) and 3'b110 (latency 2.5); every other code is reserved.
- R6: During the load, `addr[7]` is 0, `addr[8]` equals the DLL-reset flag, and every bit from `addr[9]` up to the top bit is 0.
- R7: `ba` is 2'b00 during the load.
- R8: Each accepted legal request produces exactly one load command. The block drives only NOP (3'b111) in every other cycle, including the settle window.
- R9: For a legal request, `ack` rises exactly SETTLE_CYC cycles after the cycle that shows the load, with `err` = 0.
- R10: A request with a reserved burst-length or CAS code issues no load. `ack` and `err` are both high in the cycle after the edge that first samples the request.
- R11: `ack` is a single-cycle pulse. Once the requester drops `req`, the block returns to NOP with `ack` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Load request, held until `ack` |
| req_bl | input | 3 | Burst length code |
| req_bt | input | 1 | Burst type (0 sequential, 1 interleaved) |
| req_cl | input | 3 | CAS latency code |
| req_dll_rst | input | 1 | Request a DLL reset with the load |
| banks_idle | input | 1 | All banks are precharged and idle |
| burst_active | input | 1 | A read or write burst is in progress |
| cmd_n | output | 3 | Command {ras_n, cas_n, we_n} |
| ba | output | 2 | Bank address |
| addr | output | ROW_W | Address bus |
| ack | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Request rejected, valid with `ack` |

## Verification
A wrong state register shows up within one or two cycles. Either a load appears while the status inputs report a busy bank, or a load appears before the second edge, or a request stays silent while the memory is idle. A miscounted settle counter moves `ack` off its fixed distance from the load cycle, which is visible on the very cycle it fires. A corrupted latched field appears on the address bus in the single load cycle. That is why every field is compared in that exact cycle, and every bus cycle around it is checked for NOP.

// File: rtl/sdram_mrs_loader.sv
module sdram_mrs_loader #(
  parameter int ROW_W      = 13,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       req_bl,
  input  logic             req_bt,
  input  logic [2:0]       req_cl,
  input  logic             req_dll_rst,
  input  logic             banks_idle,
  input  logic             burst_active,
  output logic [2:0]       cmd_n,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             ack,
  output logic             err
);

  localparam int OPM_W = ROW_W - 7;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_LMR = 3'b000;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SETTLE} state_t;

  state_t           state;
  logic [6:0]       low_q;
  logic             dll_q;
  logic [CNT_W-1:0] cnt;

  wire bl_ok   = (req_bl == 3'b001) || (req_bl == 3'b010) || (req_bl == 3'b011);
  wire cl_ok   = (req_cl == 3'b010) || (req_cl == 3'b110);
  wire mem_ok  = banks_idle && !burst_active;

  wire [OPM_W-1:0] opm       = {{(OPM_W-2){1'b0}}, dll_q, 1'b0};
  wire [ROW_W-1:0] mode_word = {opm, low_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      low_q <= '0;
      dll_q <= 1'b0;
      cnt   <= '0;
      cmd_n <= CMD_NOP;
      ba    <= 2'b00;
      addr  <= '0;
      ack   <= 1'b0;
      err   <= 1'b0;
    end else begin
      cmd_n <= CMD_NOP;
      ba    <= 2'b00;
      addr  <= '0;
      ack   <= 1'b0;
      err   <= 1'b0;
      case (state)
        S_IDLE: if (req && !ack) begin
          if (bl_ok && cl_ok) begin
            low_q <= {req_cl, req_bt, req_bl};
            dll_q <= req_dll_rst;
            state <= S_WAIT;
          end else begin
            ack <= 1'b1;
            err <= 1'b1;
          end
        end
        S_WAIT: if (mem_ok) begin
          cmd_n <= CMD_LMR;
          addr  <= mode_word;
          cnt   <= CNT_W'(SETTLE_CYC);
          state <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == CNT_W'(1)) begin
            ack   <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_mrs_loader_chk.sv
module sdram_mrs_loader_chk #(
  parameter int ROW_W      = 13,
  parameter int SETTLE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             banks_idle,
  input logic             burst_active,
  input logic [2:0]       cmd_n,
  input logic [1:0]       ba,
  input logic [ROW_W-1:0] addr,
  input logic             ack,
  input logic             err
);
  localparam logic [2:0] NOP = 3'b111;
  localparam logic [2:0] LMR = 3'b000;

  logic        pend;
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      since <= '0;
    end else if (cmd_n == LMR) begin
      pend  <= 1'b1;
      since <= '0;
    end else if (ack) begin
      pend <= 1'b0;
    end else if (pend && since != 16'hFFFF) begin
      since <= since + 16'd1;
    end
  end

  assert_lmr_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) |-> $past(banks_idle && !burst_active));
  assert_bl_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) |-> (addr[2:0] == 3'b001 || addr[2:0] == 3'b010 || addr[2:0] == 3'b011));
  assert_cl_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) |-> (addr[6:4] == 3'b010 || addr[6:4] == 3'b110));
  assert_opm_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) |-> (addr[7] == 1'b0 && addr[ROW_W-1:9] == '0));
  assert_base_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) |-> (ba == 2'b00));
  assert_only_nop_lmr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) || (cmd_n == NOP));
  assert_nop_after_lmr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == LMR) |=> (cmd_n == NOP));
  assert_settle_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend) |-> (since == 16'(SETTLE_CYC - 1) && !err));
  assert_reject_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pend) |-> err);
  assert_err_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ack);
  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind sdram_mrs_loader sdram_mrs_loader_chk #(.ROW_W(ROW_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .burst_active(burst_active),
  .cmd_n(cmd_n), .ba(ba), .addr(addr), .ack(ack), .err(err)
);

// File: tb/tb_sdram_mrs_loader.sv
module tb_sdram_mrs_loader;
  localparam int ROW_W = 13;
  localparam int S     = 4;
  localparam logic [2:0] NOP = 3'b111;
  localparam logic [2:0] LMR = 3'b000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] req_bl = 3'b0;
  logic req_bt = 1'b0;
  logic [2:0] req_cl = 3'b0;
  logic req_dll_rst = 1'b0;
  logic banks_idle = 1'b0;
  logic burst_active = 1'b0;
  logic [2:0] cmd_n;
  logic [1:0] ba;
  logic [ROW_W-1:0] addr;
  logic ack, err;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_mrs_loader #(.ROW_W(ROW_W), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_bl(req_bl), .req_bt(req_bt),
    .req_cl(req_cl), .req_dll_rst(req_dll_rst), .banks_idle(banks_idle),
    .burst_active(burst_active), .cmd_n(cmd_n), .ba(ba), .addr(addr),
    .ack(ack), .err(err)
  );

  function automatic bit legal_bl(input logic [2:0] c);
    return c == 3'b001 || c == 3'b010 || c == 3'b011;
  endfunction

  function automatic bit legal_cl(input logic [2:0] c);
    return c == 3'b010 || c == 3'b110;
  endfunction

  function automatic logic [ROW_W-1:0] exp_word(input logic [2:0] bl, input logic bt,
                                                input logic [2:0] cl, input logic dll);
    logic [ROW_W-1:0] w;
    w = '0;
    w[2:0] = bl;
    w[3]   = bt;
    w[6:4] = cl;
    w[8]   = dll;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic drive_status(input int n, input int busy);
    if (n < busy) begin
      banks_idle   = ($urandom % 2) == 0;
      burst_active = !banks_idle || (($urandom % 2) == 0);
    end else begin
      banks_idle   = ($urandom % 4) != 0;
      burst_active = ($urandom % 4) == 0;
    end
  endtask

  task automatic run_req(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                         input logic dll, input int busy);
    bit valid;
    bit ok_prev;
    bit done;
    int n;
    int lmr_at;
    logic [ROW_W-1:0] ew;
    valid = legal_bl(bl) && legal_cl(cl);
    ew = exp_word(bl, bt, cl, dll);
    @(negedge clk);
    req_bl = bl; req_bt = bt; req_cl = cl; req_dll_rst = dll; req = 1'b1;
    drive_status(0, busy);
    ok_prev = banks_idle && !burst_active;
    n = 0; lmr_at = -1; done = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (!valid) begin
        chk(ack && err, "R10 reject ack/err", {ack, err}, 2'b11);
        chk(cmd_n == NOP, "R10 no load on reserved code", cmd_n, NOP);
        done = 1;
      end else if (lmr_at < 0) begin
        if (n >= 2 && ok_prev) begin
          chk(cmd_n == LMR, "R2 load at first idle edge", cmd_n, LMR);
        end else begin
          chk(cmd_n == NOP, "R2 no load while busy/too early", cmd_n, NOP);
        end
        chk(!ack, "R9 no early ack", ack, 0);
        if (cmd_n == LMR) begin
          lmr_at = n;
          chk(addr[2:0] == ew[2:0], "R3 burst length field", addr[2:0], ew[2:0]);
          chk(addr[3] == ew[3], "R4 burst type field", addr[3], ew[3]);
          chk(addr[6:4] == ew[6:4], "R5 CAS field", addr[6:4], ew[6:4]);
          chk(addr[ROW_W-1:7] == ew[ROW_W-1:7], "R6 operating mode field",
              32'(addr[ROW_W-1:7]), 32'(ew[ROW_W-1:7]));
          chk(ba == 2'b00, "R7 bank address", ba, 0);
        end
      end else if (n - lmr_at < S) begin
        chk(cmd_n == NOP, "R8 NOP in settle window", cmd_n, NOP);
        chk(!ack, "R9 ack held during settle", ack, 0);
      end else begin
        chk(ack && !err, "R9 ack after settle", {ack, err}, 2'b10);
        chk(cmd_n == NOP, "R8 NOP at ack", cmd_n, NOP);
        done = 1;
      end
      if (done) req = 1'b0;
      drive_status(n, busy);
      ok_prev = banks_idle && !burst_active;
    end
    if (!done) chk(0, "watchdog request hung", n, 0);
    @(negedge clk);
    chk(!ack && cmd_n == NOP, "R11 ack single pulse, back to NOP", {ack, cmd_n}, {1'b0, NOP});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cmd_n == NOP && !ack && !err && ba == 0 && addr == 0, "R1 reset state",
        {ack, err, cmd_n}, {2'b00, NOP});
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_n == NOP && !ack && !err && addr == 0, "R1 after release",
        {ack, err, cmd_n}, {2'b00, NOP});

    run_req(3'b001, 1'b0, 3'b010, 1'b0, 0);
    run_req(3'b010, 1'b1, 3'b110, 1'b1, 0);
    run_req(3'b011, 1'b1, 3'b010, 1'b1, 20);
    run_req(3'b000, 1'b0, 3'b010, 1'b0, 0);
    run_req(3'b100, 1'b0, 3'b110, 1'b0, 0);
    run_req(3'b111, 1'b1, 3'b010, 1'b1, 0);
    run_req(3'b010, 1'b0, 3'b000, 1'b0, 0);
    run_req(3'b011, 1'b0, 3'b011, 1'b1, 0);
    run_req(3'b001, 1'b1, 3'b111, 1'b0, 0);

    for (int i = 0; i < 80; i++) begin
      logic [2:0] bl, cl;
      if (($urandom % 4) != 0) begin
        bl = 3'(($urandom % 3) + 1);
        cl = (($urandom % 2) == 0) ? 3'b010 : 3'b110;
      end else begin
        bl = 3'($urandom);
        cl = 3'($urandom);
      end
      run_req(bl, 1'($urandom), cl, 1'($urandom), int'($urandom % 8));
    end
    summary();
  end
endmodule